// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns a single burst request into the stream of per-beat column addresses that a synchronous DRAM controller puts on the command bus. It also produces the timing of the data phase. A configuration word, held steady between bursts, selects the burst length, the column ordering, the CAS latency and whether writes are cut to one beat. A request carries the bank, the starting column and the direction. From that request the block emits one beat per clock. Each beat carries its column, the bank and the direction. The block raises a write-data strobe on every write beat, and a read-data-valid strobe the configured latency after every read beat.

The request side is a valid/ready handshake. A request is taken on a rising edge where `start_valid` and `start_ready` are both high. `start_ready` is low while a burst is in flight, which includes the latency tail of a read. It is also low while the configuration is illegal. A requester that sees `start_ready` low keeps its request steady and waits. The beat and data strobes have no back-pressure, because the memory device cannot stall a burst once it has started. A terminate input ends any burst after the current beat. It is the only way to end a full-page burst.

Top module: `sdr_burst_seq`

## Requirements
- R1: The length code `cfg_len_code` selects the burst length: 0→1, 1→2, 2→4, 3→8, 7→full page. Codes 4, 5 and 6 are illegal, and so is code 7 combined with `cfg_interleave`=1. While the configuration is illegal, `cfg_err` is 1 and `start_ready` is 0, so a request produces no beat and leaves `busy` at 0.
- R2: After an accepting edge, beat 0 is presented in the next cycle with the starting column. The remaining beats follow in consecutive cycles. `beat_bank` and `beat_write` hold the request's bank and direction on every beat.
- R3: In sequential order (`cfg_interleave`=0) with length L=2^k, the low k column bits of beat n equal (start low bits + n) mod L, and the upper bits equal the starting column's.
- R4: In interleave order (`cfg_interleave`=1), the low k column bits of beat n equal the start low bits XOR n, and the upper bits are unchanged.
- R5: A full-page burst presents column (start + n) mod 2^COL_W on beat n. It runs until terminated and never raises `beat_last`.
- R6: `beat_last` is 1 on the final beat of a fixed-length burst, and no beat follows it.
- R7: When `term` is 1 during a beat cycle, that beat is the final one and no beat is presented in the next cycle.
- R8: With `cfg_single_write`=1, every write is one beat, with `beat_last`=1 and the starting column, while reads keep the configured length.
- R9: `rd_data_valid` is 1 exactly CL cycles after each read beat, where CL=2 for `cfg_cas3`=0 and CL=3 for `cfg_cas3`=1. `rd_data_last` marks the data of the final read beat.
- R10: `wr_data_ready` is 1 in every write beat cycle and never during a read. `rd_data_valid` never follows a write beat.
- R11: `busy` is 0 after reset. It is 1 from the cycle after acceptance through the last beat of a write, or through the last `rd_data_valid` cycle of a read. `start_ready` equals NOT `busy` whenever the configuration is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len_code | input | 3 | Burst length code |
| cfg_interleave | input | 1 | 1 = interleave order, 0 = sequential |
| cfg_cas3 | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| cfg_single_write | input | 1 | 1 = writes are single-beat |
| cfg_err | output | 1 | Configuration is illegal |
| start_valid | input | 1 | Burst request present |
| start_ready | output | 1 | Request can be accepted this cycle |
| start_bank | input | BANK_W | Bank of the request |
| start_col | input | COL_W | Starting column |
| start_write | input | 1 | 1 = write, 0 = read |
| term | input | 1 | End the burst after the current beat |
| beat_valid | output | 1 | A beat is presented |
| beat_bank | output | BANK_W | Bank of the beat |
| beat_col | output | COL_W | Column of the beat |
| beat_write | output | 1 | Direction of the beat |
| beat_last | output | 1 | Final beat of a fixed-length burst |
| wr_data_ready | output | 1 | Write data is taken this cycle |
| rd_data_valid | output | 1 | Read data is valid this cycle |
| rd_data_last | output | 1 | Read data of the final beat |
| busy | output | 1 | Burst or read latency tail in progress |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a terminate and the natural final beat. The bench raises `term` on exactly the beat that already carries `beat_last`, and expects the burst to end there with the same data tail as an unterminated burst. The second pair is the last read-data strobe and a waiting request. The bench holds `start_valid` high through a CL=3 read. It requires `start_ready` to stay low up to and including the final `rd_data_valid` cycle, to rise in the following cycle, and the next burst's beat 0 to appear one cycle after that.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  localparam int LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] LEN_PAGE = 3'd7;
  localparam logic [LEN_CODE_W-1:0] LEN_MAX_FIXED = 3'd3;

  typedef struct packed {
    logic       err;
    logic       full;
    logic [2:0] last_idx;
  } len_dec_t;
endpackage

// File: rtl/sdr_cfg_decode.sv
module sdr_cfg_decode
  import sdr_seq_pkg::*;
(
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  interleave,
  output len_dec_t              dec
);
  logic fixed_ok;

  always_comb begin
    fixed_ok     = (len_code <= LEN_MAX_FIXED);
    dec.full     = (len_code == LEN_PAGE);
    dec.err      = !(fixed_ok || dec.full) || (dec.full && interleave);
    dec.last_idx = fixed_ok ? 3'((4'd1 << len_code[1:0]) - 4'd1) : 3'd0;
  end
endmodule

// File: rtl/sdr_col_gen.sv
module sdr_col_gen #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             interleave,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] moving;

  always_comb begin
    moving = interleave ? (base ^ idx) : (base + idx);
    col    = (base & ~mask) | (moving & mask);
  end
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
  parameter int MAX_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  input  logic lat_max,
  output logic out_valid,
  output logic out_last,
  output logic pending
);
  logic [MAX_LAT-1:0] v_q;
  logic [MAX_LAT-1:0] l_q;
  int unsigned tap;

  for (genvar i = 0; i < MAX_LAT; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[0] <= 1'b0;
          l_q[0] <= 1'b0;
        end else begin
          v_q[0] <= in_valid;
          l_q[0] <= in_valid && in_last;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[i] <= 1'b0;
          l_q[i] <= 1'b0;
        end else begin
          v_q[i] <= v_q[i-1];
          l_q[i] <= l_q[i-1];
        end
      end
    end
  end

  always_comb begin
    tap       = lat_max ? MAX_LAT - 1 : MAX_LAT - 2;
    out_valid = v_q[tap];
    out_last  = l_q[tap];
    pending   = 1'b0;
    for (int i = 0; i < MAX_LAT; i++) begin
      if (i <= int'(tap)) pending = pending | v_q[i];
    end
  end

  // R9: read data emerges exactly the latency after the read beat
  assert_rd_delay_long_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lat_max && out_valid |-> $past(in_valid, 3));
  assert_rd_delay_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_max && out_valid |-> $past(in_valid, 2));
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_seq_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LEN_CODE_W-1:0] cfg_len_code,
  input  logic                  cfg_interleave,
  input  logic                  cfg_cas3,
  input  logic                  cfg_single_write,
  output logic                  cfg_err,
  input  logic                  start_valid,
  output logic                  start_ready,
  input  logic [BANK_W-1:0]     start_bank,
  input  logic [COL_W-1:0]      start_col,
  input  logic                  start_write,
  input  logic                  term,
  output logic                  beat_valid,
  output logic [BANK_W-1:0]     beat_bank,
  output logic [COL_W-1:0]      beat_col,
  output logic                  beat_write,
  output logic                  beat_last,
  output logic                  wr_data_ready,
  output logic                  rd_data_valid,
  output logic                  rd_data_last,
  output logic                  busy
);
  localparam int MAX_LAT = 3;

  len_dec_t          dec;
  logic              run_q, wr_q, intl_q, full_q, lat3_q, single_q;
  logic [COL_W-1:0]  idx_q, base_q, mask_w, col_w;
  logic [BANK_W-1:0] bank_q;
  logic [2:0]        last_q;
  logic              accept, one_beat, final_beat, rd_pending;

  sdr_cfg_decode u_dec (
    .len_code   (cfg_len_code),
    .interleave (cfg_interleave),
    .dec        (dec)
  );

  assign cfg_err     = dec.err;
  assign start_ready = !busy && !dec.err;
  assign accept      = start_valid && start_ready;
  assign one_beat    = cfg_single_write && start_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
      bank_q   <= '0;
      wr_q     <= 1'b0;
      intl_q   <= 1'b0;
      full_q   <= 1'b0;
      last_q   <= '0;
      lat3_q   <= 1'b0;
      single_q <= 1'b0;
    end else if (accept) begin
      run_q    <= 1'b1;
      idx_q    <= '0;
      base_q   <= start_col;
      bank_q   <= start_bank;
      wr_q     <= start_write;
      intl_q   <= cfg_interleave;
      full_q   <= dec.full && !one_beat;
      last_q   <= one_beat ? 3'd0 : dec.last_idx;
      lat3_q   <= cfg_cas3;
      single_q <= cfg_single_write;
    end else if (run_q) begin
      if (final_beat) run_q <= 1'b0;
      else            idx_q <= idx_q + 1'b1;
    end
  end

  assign mask_w = full_q ? {COL_W{1'b1}} : COL_W'(last_q);

  sdr_col_gen #(.COL_W(COL_W)) u_col (
    .base       (base_q),
    .idx        (idx_q),
    .mask       (mask_w),
    .interleave (intl_q),
    .col        (col_w)
  );

  assign beat_valid    = run_q;
  assign beat_bank     = bank_q;
  assign beat_col      = col_w;
  assign beat_write    = wr_q;
  assign beat_last     = run_q && !full_q && (idx_q == COL_W'(last_q));
  assign final_beat    = run_q && (beat_last || term);
  assign wr_data_ready = run_q && wr_q;

  sdr_rd_pipe #(.MAX_LAT(MAX_LAT)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (run_q && !wr_q),
    .in_last   (final_beat),
    .lat_max   (lat3_q),
    .out_valid (rd_data_valid),
    .out_last  (rd_data_last),
    .pending   (rd_pending)
  );

  assign busy = run_q || rd_pending;

  assert_err_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && !busy |=> !beat_valid);
  assert_bank_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && $past(beat_valid) |-> $stable(beat_bank) && $stable(beat_write));
  assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_last |=> !beat_valid);
  assert_term_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && term |=> !beat_valid);
  assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_write && single_q |-> beat_last);
  assert_no_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_valid |-> !wr_data_ready);
  assert_busy_tail_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_valid |-> busy && !start_ready);
endmodule

// File: tb/sdr_burst_seq_tb.sv
module sdr_burst_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_len_code = 3'd0;
  logic       cfg_interleave = 1'b0, cfg_cas3 = 1'b0, cfg_single_write = 1'b0;
  logic       start_valid = 1'b0, start_write = 1'b0, term = 1'b0;
  logic [1:0] start_bank = 2'd0;
  logic [9:0] start_col = 10'd0;
  logic       cfg_err, start_ready, beat_valid, beat_write, beat_last;
  logic       wr_data_ready, rd_data_valid, rd_data_last, busy;
  logic [1:0] beat_bank;
  logic [9:0] beat_col;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  sdr_burst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_len_code(cfg_len_code),
    .cfg_interleave(cfg_interleave), .cfg_cas3(cfg_cas3),
    .cfg_single_write(cfg_single_write), .cfg_err(cfg_err),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_bank(start_bank), .start_col(start_col), .start_write(start_write),
    .term(term), .beat_valid(beat_valid), .beat_bank(beat_bank),
    .beat_col(beat_col), .beat_write(beat_write), .beat_last(beat_last),
    .wr_data_ready(wr_data_ready), .rd_data_valid(rd_data_valid),
    .rd_data_last(rd_data_last), .busy(busy)
  );

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  function automatic int exp_col(input int col, input int n, input int len, input bit il);
    int lo, base;
    if (len == 0) return (col + n) % 1024;
    lo   = col % len;
    base = col - lo;
    return il ? base + (lo ^ n) : base + ((lo + n) % len);
  endfunction

  task automatic set_cfg(input int len, input bit il, input bit cas3, input bit sw);
    @(negedge clk);
    cfg_len_code = 3'(len); cfg_interleave = il; cfg_cas3 = cas3; cfg_single_write = sw;
    #1;
  endtask

  // len: 0 = full page; term_at < 0 = no terminate; last_at < 0 = no beat_last
  task automatic run_burst(input string tag, input int bank, input int col, input bit wr,
                           input int n_exp, input int term_at, input int last_at,
                           input int len, input bit il, input int cl);
    int got, exp;
    @(negedge clk);
    start_valid = 1'b1; start_bank = 2'(bank); start_col = 10'(col); start_write = wr;
    check(tag, "start_ready", int'(start_ready), 1);
    @(posedge clk);
    for (int c = 0; c < n_exp + cl + 2; c++) begin
      @(negedge clk);
      start_valid = 1'b0;
      term = (c == term_at);
      #0.5;
      exp = {(c < n_exp), (c == last_at), (wr && c < n_exp),
             (!wr && c >= cl && c - cl < n_exp), (!wr && c - cl == n_exp - 1),
             (c < n_exp + (wr ? 0 : cl)), (c < n_exp) ? wr : 1'b0};
      got = {beat_valid, beat_last, wr_data_ready, rd_data_valid, rd_data_last, busy,
             beat_valid ? beat_write : 1'b0};
      check(tag, $sformatf("strobes c=%0d", c), got, exp);
      if (c < n_exp) begin
        check(tag, $sformatf("col c=%0d", c), int'(beat_col), exp_col(col, c, len, il));
        check("R2", $sformatf("bank c=%0d", c), int'(beat_bank), bank);
      end
    end
    term = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11", "busy after reset", int'(busy), 0);
    check("R11", "ready after reset", int'(start_ready), 1);
    check("R2", "no beat after reset", int'(beat_valid), 0);
    check("R1", "err after reset", int'(cfg_err), 0);
  endtask

  task automatic t_seq();
    set_cfg(2, 0, 0, 0);
    run_burst("R3", 1, 10'h0E6, 0, 4, -1, 3, 4, 0, 2);
    set_cfg(3, 0, 1, 0);
    run_burst("R10", 2, 10'h015, 1, 8, -1, 7, 8, 0, 3);
    set_cfg(0, 0, 1, 0);
    run_burst("R1", 3, 10'h123, 0, 1, -1, 0, 1, 0, 3);
  endtask

  task automatic t_intl();
    set_cfg(3, 1, 1, 0);
    run_burst("R4", 0, 10'h02D, 0, 8, -1, 7, 8, 1, 3);
    set_cfg(1, 1, 0, 0);
    run_burst("R4", 2, 10'h3FF, 1, 2, -1, 1, 2, 1, 2);
  endtask

  task automatic t_full();
    set_cfg(7, 0, 1, 0);
    run_burst("R5", 1, 10'h3FE, 0, 5, 4, -1, 0, 0, 3);
  endtask

  task automatic t_term();
    set_cfg(3, 0, 0, 0);
    run_burst("R7", 2, 10'h104, 0, 3, 2, -1, 8, 0, 2);
    set_cfg(2, 0, 1, 0);
    run_burst("R7", 0, 10'h009, 0, 4, 3, 3, 4, 0, 3);
  endtask

  task automatic t_single();
    set_cfg(3, 0, 0, 1);
    run_burst("R8", 3, 10'h0A3, 1, 1, -1, 0, 1, 0, 2);
    run_burst("R8", 3, 10'h0A3, 0, 8, -1, 7, 8, 0, 2);
    set_cfg(7, 0, 0, 1);
    run_burst("R8", 1, 10'h200, 1, 1, -1, 0, 1, 0, 2);
  endtask

  task automatic t_err();
    set_cfg(5, 0, 0, 0);
    check("R1", "err code 5", int'(cfg_err), 1);
    check("R1", "ready code 5", int'(start_ready), 0);
    start_valid = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R1", "no beat code 5", int'({beat_valid, busy}), 0);
    end
    set_cfg(7, 1, 0, 0);
    check("R1", "err page+interleave", int'(cfg_err), 1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R1", "no beat page+interleave", int'({beat_valid, busy}), 0);
    end
    start_valid = 1'b0;
    set_cfg(7, 0, 0, 0);
    check("R1", "page sequential legal", int'(cfg_err), 0);
  endtask

  task automatic t_b2b();
    set_cfg(1, 0, 1, 0);
    @(negedge clk);
    start_valid = 1'b1; start_bank = 2'd1; start_col = 10'h040; start_write = 1'b0;
    @(posedge clk);
    for (int c = 0; c < 7; c++) begin
      @(negedge clk);
      if (c <= 4) check("R11", $sformatf("ready low c=%0d", c), int'(start_ready), 0);
      if (c == 4) check("R9", "final rd strobe", int'({rd_data_valid, rd_data_last}), 3);
      if (c == 5) check("R11", "ready after tail", int'({start_ready, busy}), 2);
      if (c == 6) begin
        check("R2", "second beat0 valid", int'(beat_valid), 1);
        check("R2", "second beat0 col", int'(beat_col), 'h040);
        start_valid = 1'b0;
      end
    end
    for (int c = 0; c < 20 && busy; c++) @(negedge clk);
    check("R11", "idle after second", int'(busy), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_seq();
    t_intl();
    t_full();
    t_term();
    t_single();
    t_err();
    t_b2b();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule